// File: doc/BRIEF.md
# Signed-Digit Stream to Two's-Complement Converter

This block turns a serial stream of radix-2 signed digits into an ordinary two's-complement number. Each digit has a value of -1, 0 or +1, and the stream arrives most significant digit first. A producer such as a left-to-right serial multiplier delivers the digits, one digit per strobed cycle. The block folds each digit into the running result in the cycle it arrives. No carry-propagate adder is used, so the logic delay per digit does not depend on the word length.

Inside, two registers are kept. The first holds the value of the digits taken so far. The second holds that value minus one unit in the last place. On every digit each register takes a left shift of one of the two registers and appends a fixed bit. The block never subtracts a negative vector from a positive one. After `N` digits a one-cycle ready flag marks a complete word on the parallel output. The next strobed digit then opens a new word.

The output is `N+1` bits wide. Any string of `N` signed digits gives a value between -(2^N - 1) and 2^N - 1, and that range needs the extra sign bit to be exact.

Top module: `otf_sd_converter`

## Requirements
- R1: After reset (`rst_n` low at a clock edge) or a synchronous `clear_i` pulse, `result_o` is zero, `ready_o` is low and `err_o` is low. A clear in the middle of a word discards that word, and the following `N` digits form a fresh word. `clear_i` takes priority over `valid_i`.
- R2: The digit encoding on the pair (`dig_pos_i`, `dig_neg_i`) is as follows: 1,0 means +1; 0,1 means -1; 0,0 means 0.
- R3: When a word of `N` digits d1..dN completes, `result_o` equals the sum of di·2^(N-i) as an (N+1)-bit two's-complement number.
- R4: In the cycle after every valid digit, `result_o` shows the two's-complement value of the digits received so far in the current word. After k digits this is the sum of di·2^(k-i).
- R5: `ready_o` is high for exactly the one cycle that follows the valid digit completing a word of `N` digits. It is low after any earlier digit of the word.
- R6: A cycle with `valid_i` low changes neither the output nor the conversion state. Idle gaps between digits therefore give the same final result as back-to-back digits.
- R7: The first valid digit after a completed word starts a new word from a value of zero.
- R8: The pair 1,1 is a forbidden encoding. It is counted as a digit of value 0, and `err_o` goes high in the following cycle. `err_o` then stays high until reset, a clear, or the first digit of the next word, unless that digit is itself forbidden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the word in progress |
| valid_i | input | 1 | A digit is present on the digit pair this cycle |
| dig_pos_i | input | 1 | Positive half of the signed digit |
| dig_neg_i | input | 1 | Negative half of the signed digit |
| result_o | output | N+1 | Two's-complement value of the digits so far |
| ready_o | output | 1 | One-cycle flag: a full word of N digits is on result_o |
| err_o | output | 1 | A forbidden digit was seen in the current word |

## Verification
Table words are fed through a single loop:
- Words of all +1 and of all -1 reach the two ends of the range and exercise the sign bit.
- Words that mix a leading digit of one sign with a tail of the other sign make the result switch to the minus-one register. This separates a correct selection between the two registers from plain shifting.
- Alternating patterns and the all-zero word test every bit position.
- A word containing forbidden pairs shows that these pairs count as zero digits and set the error flag.

Directed tests cover the following:
- the partial value after each of the first digits of a word;
- idle gaps inside a word;
- a clear in the middle of a word;
- that the ready pulse lasts one cycle;
- the restart from zero after a completed word.

// File: rtl/otf_pkg.sv
// Shared types for the signed-digit converter.
// Assumes: a digit is carried as a positive/negative bit pair.
package otf_pkg;

    // Decoded value of one radix-2 signed digit
    typedef enum logic [1:0] {
        SD_ZERO  = 2'd0,
        SD_PLUS  = 2'd1,
        SD_MINUS = 2'd2
    } sd_digit_e;

endpackage

// File: rtl/otf_digit_decode.sv
// Decodes the positive/negative bit pair into a signed digit.
// Assumes: 1,0 = +1; 0,1 = -1; 0,0 = 0; 1,1 is forbidden and maps to 0
// while raising bad_o. Purely combinational.
module otf_digit_decode
    import otf_pkg::*;
(
    input  logic      pos_i,
    input  logic      neg_i,
    output sd_digit_e dig_o,
    output logic      bad_o
);

    // Map the bit pair to a digit value; the forbidden pair reads as zero
    always_comb begin
        bad_o = pos_i & neg_i;
        unique case ({pos_i, neg_i})
            2'b10:   dig_o = SD_PLUS;
            2'b01:   dig_o = SD_MINUS;
            default: dig_o = SD_ZERO;
        endcase
    end

endmodule

// File: rtl/otf_word_counter.sv
// Counts the digits of the current word and flags word completion.
// Assumes: a word is exactly N accepted digits; the digit that follows a
// full word opens the next one. fresh_o tells the datapath to start from
// zero on the current step. ready_o is registered and lasts one cycle
// per completed word.
module otf_word_counter #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic fresh_o,
    output logic ready_o
);

    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    // A new word starts when nothing has been taken yet or the last word is done
    always_comb begin
        fresh_o = (cnt_q == CW'(0)) || (cnt_q == CW'(N));
        cnt_nx  = fresh_o ? CW'(1) : cnt_q + CW'(1);
    end

    // Advance the digit count and raise ready after the N-th digit
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q   <= '0;
            ready_o <= 1'b0;
        end else begin
            ready_o <= step_i && (cnt_nx == CW'(N));
            if (step_i) begin
                cnt_q <= cnt_nx;
            end
        end
    end

endmodule

// File: rtl/otf_candidate_pair.sv
// Holds the two candidate registers of the conversion: the value so far
// (q) and that value minus one unit in the last place (qm). Each digit
// shifts one register of the pair into each target and appends a fixed
// bit, so there is no carry chain.
// Assumes: W bits are enough for any word value and for that value minus one.
module otf_candidate_pair
    import otf_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic         fresh_i,
    input  sd_digit_e    dig_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] qm_o
);

    logic [W-1:0] base_q;
    logic [W-1:0] base_qm;
    logic [W-1:0] src_q;
    logic [W-1:0] src_qm;
    logic         app_q;
    logic         app_qm;
    logic [W-1:0] q_nx;
    logic [W-1:0] qm_nx;

    // Select the source register and the appended bit for each target
    always_comb begin
        base_q  = fresh_i ? '0 : q_o;
        base_qm = fresh_i ? '1 : qm_o;
        src_q   = (dig_i == SD_MINUS) ? base_qm : base_q;
        src_qm  = (dig_i == SD_PLUS)  ? base_q  : base_qm;
        app_q   = (dig_i != SD_ZERO);
        app_qm  = (dig_i == SD_ZERO);
    end

    // The shift itself is pure wiring: bit b takes bit b-1 of the source
    assign q_nx[0]  = app_q;
    assign qm_nx[0] = app_qm;
    for (genvar b = 1; b < W; b++) begin : g_shift
        assign q_nx[b]  = src_q[b-1];
        assign qm_nx[b] = src_qm[b-1];
    end

    // Load the candidate pair on each accepted digit
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            q_o  <= '0;
            qm_o <= '1;
        end else if (step_i) begin
            q_o  <= q_nx;
            qm_o <= qm_nx;
        end
    end

endmodule

// File: rtl/otf_sd_converter.sv
// Top level: converts a most-significant-first stream of signed digits
// into an (N+1)-bit two's-complement word without carry propagation.
// Assumes: one digit per cycle with valid_i high; clear_i takes priority
// over valid_i; the output always shows the value of the digits so far.
module otf_sd_converter
    import otf_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         valid_i,
    input  logic         dig_pos_i,
    input  logic         dig_neg_i,
    output logic [N:0]   result_o,
    output logic         ready_o,
    output logic         err_o
);

    localparam int W = N + 1;

    sd_digit_e    dig;
    logic         bad;
    logic         step;
    logic         fresh;
    logic [W-1:0] q_w;
    logic [W-1:0] qm_w;

    assign step = valid_i && !clear_i;

    otf_digit_decode u_dec (
        .pos_i (dig_pos_i),
        .neg_i (dig_neg_i),
        .dig_o (dig),
        .bad_o (bad)
    );

    otf_word_counter #(.N(N)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .step_i  (step),
        .fresh_o (fresh),
        .ready_o (ready_o)
    );

    otf_candidate_pair #(.W(W)) u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .step_i  (step),
        .fresh_i (fresh),
        .dig_i   (dig),
        .q_o     (q_w),
        .qm_o    (qm_w)
    );

    // Keep the forbidden-digit flag for the rest of the word
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            err_o <= 1'b0;
        end else if (step) begin
            err_o <= bad || (!fresh && err_o);
        end
    end

    assign result_o = q_w;

endmodule

// File: rtl/otf_sd_converter_chk.sv
// Assertion checker bound to the converter top level.
// Assumes: reset is synchronous and active low.
module otf_sd_converter_chk #(
    parameter int N = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clear_i,
    input logic       valid_i,
    input logic       dig_pos_i,
    input logic       dig_neg_i,
    input logic [N:0] result_o,
    input logic [N:0] qm_w,
    input logic       ready_o,
    input logic       err_o
);

    assert_clear_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (result_o == '0) && !ready_o && !err_o);

    assert_pair_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (N+1)'(result_o - qm_w) == (N+1)'(1));

    assert_ready_after_digit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> $past(valid_i) && !$past(clear_i));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clear_i) |=> $stable(result_o) && !ready_o && $stable(err_o));

    assert_bad_digit_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i && dig_pos_i && dig_neg_i) |=> err_o);

endmodule

bind otf_sd_converter otf_sd_converter_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .valid_i   (valid_i),
    .dig_pos_i (dig_pos_i),
    .dig_neg_i (dig_neg_i),
    .result_o  (result_o),
    .qm_w      (qm_w),
    .ready_o   (ready_o),
    .err_o     (err_o)
);

// File: tb/tb_otf_sd_converter.sv
module tb_otf_sd_converter;

    localparam int N = 8;

    typedef struct packed {
        logic [N-1:0] p;
        logic [N-1:0] m;
        logic [N:0]   e;
        logic         er;
    } vec_t;

    // Digit i of a word is bit N-1-i of p/m (most significant digit first)
    localparam vec_t VEC [9] = '{
        '{p: 8'hFF, m: 8'h00, e: 9'h0FF, er: 1'b0},
        '{p: 8'h00, m: 8'hFF, e: 9'h101, er: 1'b0},
        '{p: 8'h80, m: 8'h7F, e: 9'h001, er: 1'b0},
        '{p: 8'h01, m: 8'h80, e: 9'h181, er: 1'b0},
        '{p: 8'hAA, m: 8'h55, e: 9'h055, er: 1'b0},
        '{p: 8'h55, m: 8'hAA, e: 9'h1AB, er: 1'b0},
        '{p: 8'h00, m: 8'h00, e: 9'h000, er: 1'b0},
        '{p: 8'hF0, m: 8'h0F, e: 9'h0E1, er: 1'b0},
        '{p: 8'hC1, m: 8'h41, e: 9'h080, er: 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       valid_i = 1'b0;
    logic       dig_pos_i = 1'b0;
    logic       dig_neg_i = 1'b0;
    logic [N:0] result_o;
    logic       ready_o;
    logic       err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    otf_sd_converter #(.N(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .valid_i   (valid_i),
        .dig_pos_i (dig_pos_i),
        .dig_neg_i (dig_neg_i),
        .result_o  (result_o),
        .ready_o   (ready_o),
        .err_o     (err_o)
    );

    task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Presents one digit for one cycle, then returns at the following
    // negedge with valid low, when the registered outputs show that digit
    task automatic send_digit(input logic p, input logic m, input int gap);
        @(negedge clk);
        valid_i = 1'b1; dig_pos_i = p; dig_neg_i = m;
        @(negedge clk);
        valid_i = 1'b0; dig_pos_i = 1'b0; dig_neg_i = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // Sends a whole word back to back; returns with ready visible
    task automatic send_word(input logic [N-1:0] p, input logic [N-1:0] m);
        for (int i = N - 1; i >= 0; i--) begin
            @(negedge clk);
            valid_i = 1'b1; dig_pos_i = p[i]; dig_neg_i = m[i];
        end
        @(negedge clk);
        valid_i = 1'b0; dig_pos_i = 1'b0; dig_neg_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state after reset
        check("R1 reset result", result_o, '0);
        check("R1 reset ready", {{N{1'b0}}, ready_o}, '0);
        check("R1 reset err", {{N{1'b0}}, err_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5: table of words, one loop
        for (int v = 0; v < 9; v++) begin
            send_word(VEC[v].p, VEC[v].m);
            check($sformatf("R3 R2 word %0d result", v), result_o, VEC[v].e);
            check($sformatf("R5 word %0d ready", v), {{N{1'b0}}, ready_o}, 9'd1);
            check($sformatf("R8 word %0d err", v), {{N{1'b0}}, err_o}, {{N{1'b0}}, VEC[v].er});
            @(negedge clk);
            check($sformatf("R5 word %0d ready one cycle", v), {{N{1'b0}}, ready_o}, '0);
        end

        // R7: after the forbidden word, a new word starts from zero and clears err
        send_digit(1'b1, 1'b0, 0);
        check("R7 restart value", result_o, 9'h001);
        check("R8 err cleared by new word", {{N{1'b0}}, err_o}, '0);
        check("R5 no ready mid word", {{N{1'b0}}, ready_o}, '0);

        // R1: clear mid word, then a full word is unaffected by the discarded part
        send_digit(1'b0, 1'b1, 0);
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        check("R1 clear result", result_o, '0);
        check("R1 clear ready", {{N{1'b0}}, ready_o}, '0);
        send_word(8'hFF, 8'h00);
        check("R1 word after clear", result_o, 9'h0FF);
        check("R1 ready after clear word", {{N{1'b0}}, ready_o}, 9'd1);

        // R4: partial values after each digit, with R6 idle gaps between
        send_digit(1'b0, 1'b1, 0);
        check("R4 after -1", result_o, 9'h1FF);
        send_digit(1'b1, 1'b0, 3);
        check("R4 R6 after -1,+1 and idle", result_o, 9'h1FF);
        send_digit(1'b0, 1'b0, 0);
        check("R4 after -1,+1,0", result_o, 9'h1FE);
        check("R6 no ready during gaps", {{N{1'b0}}, ready_o}, '0);
        // R8: forbidden pair mid word counts as zero and raises err next cycle
        send_digit(1'b1, 1'b1, 2);
        check("R8 forbidden as zero", result_o, 9'h1FC);
        check("R8 err raised", {{N{1'b0}}, err_o}, 9'd1);
        // remaining digits 0,+1,+1,-1 with gaps: -1,1,0,0,0,1,1,-1 -> -128+64+4+2-1 = -59
        send_digit(1'b0, 1'b0, 1);
        send_digit(1'b1, 1'b0, 2);
        send_digit(1'b1, 1'b0, 0);
        @(negedge clk);
        valid_i = 1'b1; dig_pos_i = 1'b0; dig_neg_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0; dig_neg_i = 1'b0;
        check("R6 R3 gapped word result", result_o, 9'h1C5);
        check("R5 gapped word ready", {{N{1'b0}}, ready_o}, 9'd1);
        check("R8 err held to word end", {{N{1'b0}}, err_o}, 9'd1);
        repeat (2) @(negedge clk);
        check("R6 idle keeps result", result_o, 9'h1C5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule